// File: doc/BRIEF.md
# Core Reset and Cache Flush Control Register

This block is one memory-mapped control word for a single processor core. Software uses it to reset the core and to ask the core's L2 cache for a flush. Each write is masked. A control bit in the lower half of the data word is only updated when its partner bit, sixteen places higher, is also one in the same write. Because of this, software never has to read, modify and write the word back.

A reset change is never applied while the core clock runs. The block first gates the clock off and waits a programmable number of quarter-microsecond ticks. It then moves the reset line and waits the same interval again. Finally it turns the clock back on and, when the core has come out of reset, raises a sticky done flag. The flag is cleared by writing one to it. A second register holds the interval.

Two variants are selected by a parameter. The boot-core variant runs a complete pulse from one write and then clears the reset bit itself. The secondary-core variant holds reset until software writes the bit back to zero. The flush request bit is set by software and is dropped by the block when the cache reports completion.

Top module: `cpu_rst_ctl`

## Requirements
- R1: After reset, the control word (byte address 0x0) reads 0. The interval word (byte address 0x4, bits 3:0) reads 15. core_rst is 0, core_clk_en is 1 and flush_req is 0.
- R2: A write to the control word changes the reset bit (bit 0), the flush bit (bit 4) or the done bit (bit 12) only when bit 16, 20 or 28 respectively is also one in that write. Bits 31:16 always read as zero.
- R3: The interval register takes bits 3:0 of a write to byte address 0x4 and reads them back.
- R4: Boot-core variant: writing 1 to the reset bit with its mask bit set starts a pulse. With interval N and tick_en held high, the clock is stopped for 3(N+1) cycles and core_rst is high for the middle N+1 of them. Afterwards the reset bit reads 0 and the done bit reads 1.
- R5: Secondary-core variant: writing 1 to the reset bit keeps it at 1. The clock is stopped for 2(N+1) cycles, and core_rst rises N+1 cycles into the stop and stays high. No done flag is raised.
- R6: Secondary-core variant: writing 0 to a set reset bit stops the clock for 2(N+1) cycles. core_rst falls after the first N+1 of them. The done bit then reads 1.
- R7: core_rst only changes on a clock edge at which core_clk_en was already low.
- R8: The done bit is cleared only by a write with both bit 12 and bit 28 set. A write with bit 12 alone leaves it at 1.
- R9: Writing 1 to the flush bit with bit 20 set raises flush_req. Writing 0 to it has no effect. A cycle with flush_done high while the request is pending clears it at the next edge, and the clear takes priority over a new set in that cycle.
- R10: Writes to the reset bit are ignored while a sequence is running. In the boot-core variant, writing 0 to the reset bit is always ignored.
- R11: Interval counting advances only on cycles with tick_en high. With tick_en held low, the clock stays stopped indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | One-cycle pulse every 0.25 us |
| flush_done | input | 1 | Cache reports flush complete |
| core_rst | output | 1 | Active-high core reset |
| core_clk_en | output | 1 | Core clock enable |
| flush_req | output | 1 | L2 flush request |

## Verification
Four properties are checked on every cycle by the bound checker:
- the reset line never moves while the core clock is enabled;
- the done flag only rises together with the clock coming back on and the core out of reset;
- a pending flush always drops after flush_done, and an unmasked write never raises it;
- a done clear takes effect whenever it is requested while the block is idle, and done is not lost without a clear write.

The exact stop lengths of 3(N+1) and 2(N+1) cycles, the auto-clearing of the reset bit, the ignored writes during a sequence and the stall with no ticks are shown only by the bench's directed scenarios. Random masked writes then exercise the mask logic against a bench model of the flush and done bits.

// File: rtl/cpu_rst_ctl.sv
module cpu_rst_ctl #(
  parameter bit AUTO_CLEAR = 1'b1,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 4,
  parameter int CNT_INIT   = 15,
  parameter int CTRL_ADDR  = 0,
  parameter int IVAL_ADDR  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  input  logic              flush_done,
  output logic              core_rst,
  output logic              core_clk_en,
  output logic              flush_req
);
  localparam int RST_BIT   = 0;
  localparam int FLUSH_BIT = 4;
  localparam int DONE_BIT  = 12;
  localparam int WE_SHIFT  = 16;
  localparam logic [CNT_W-1:0] IVAL_RST = CNT_W'(CNT_INIT);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_MID, S_POST} seq_t;

  seq_t             st;
  logic [CNT_W-1:0] ival_q, hold_q, cnt_q;
  logic             rst_q, flush_q, done_q, core_q;

  wire ctrl_wr   = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
  wire ival_wr   = bus_we && (bus_addr == ADDR_W'(IVAL_ADDR));
  wire rst_we    = ctrl_wr && bus_wdata[RST_BIT+WE_SHIFT];
  wire rst_val   = bus_wdata[RST_BIT];
  wire flush_set = ctrl_wr && bus_wdata[FLUSH_BIT+WE_SHIFT] && bus_wdata[FLUSH_BIT];
  wire done_clr  = ctrl_wr && bus_wdata[DONE_BIT+WE_SHIFT] && bus_wdata[DONE_BIT];
  wire idle      = (st == S_IDLE);
  wire hold_end  = (cnt_q == hold_q);
  wire seq_done  = (st == S_POST) && hold_end && !core_q;
  wire start     = idle && rst_we && (AUTO_CLEAR ? rst_val : (rst_val != rst_q));

  logic unused_bits;
  assign unused_bits = ^bus_wdata;

  assign core_rst    = core_q;
  assign core_clk_en = idle;
  assign flush_req   = flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q  <= IVAL_RST;
      flush_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (ival_wr) ival_q <= bus_wdata[CNT_W-1:0];
      if (flush_q && flush_done) flush_q <= 1'b0;
      else if (flush_set)        flush_q <= 1'b1;
      if (seq_done)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt_q  <= '0;
      hold_q <= '0;
      rst_q  <= 1'b0;
      core_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rst_q  <= AUTO_CLEAR ? 1'b1 : rst_val;
          hold_q <= ival_q;
          cnt_q  <= '0;
          st     <= S_PRE;
        end
        S_PRE: if (hold_end) begin
          cnt_q  <= '0;
          core_q <= rst_q;
          st     <= AUTO_CLEAR ? S_MID : S_POST;
        end else if (tick_en) cnt_q <= cnt_q + 1'b1;
        S_MID: if (hold_end) begin
          cnt_q  <= '0;
          core_q <= 1'b0;
          rst_q  <= 1'b0;
          st     <= S_POST;
        end else if (tick_en) cnt_q <= cnt_q + 1'b1;
        S_POST: if (hold_end) st <= S_IDLE;
                else if (tick_en) cnt_q <= cnt_q + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[RST_BIT]   = rst_q;
      bus_rdata[FLUSH_BIT] = flush_q;
      bus_rdata[DONE_BIT]  = done_q;
    end else if (bus_addr == ADDR_W'(IVAL_ADDR)) begin
      bus_rdata[CNT_W-1:0] = ival_q;
    end
  end
endmodule

// File: rtl/cpu_rst_ctl_chk.sv
module cpu_rst_ctl_chk #(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              flush_done,
  input logic              core_rst,
  input logic              core_clk_en,
  input logic              flush_req,
  input logic              done_q
);
  wire cwr = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

  a_r7_rst_moves_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst != $past(core_rst)) |-> !$past(core_clk_en));

  a_r6_done_with_clock_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (core_clk_en && !core_rst));

  a_r9_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && flush_done) |=> !flush_req);

  a_r2_flush_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && !bus_wdata[20] && !flush_req) |=> !flush_req);

  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr && bus_wdata[12] && bus_wdata[28] && core_clk_en) |=> !done_q);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(cwr && bus_wdata[28])) |=> done_q);
endmodule

bind cpu_rst_ctl cpu_rst_ctl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .flush_done(flush_done), .core_rst(core_rst),
  .core_clk_en(core_clk_en), .flush_req(flush_req), .done_q(done_q));

// File: tb/cpu_rst_ctl_test.sv
module cpu_rst_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, fdone = 1'b0;
  logic we_a = 1'b0, we_m = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rd_a, rd_m;
  logic crst_a, cen_a, fr_a, crst_m, cen_m, fr_m;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_rst_ctl #(.AUTO_CLEAR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(we_a), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_a), .tick_en(tick), .flush_done(fdone), .core_rst(crst_a),
    .core_clk_en(cen_a), .flush_req(fr_a));

  cpu_rst_ctl #(.AUTO_CLEAR(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .bus_we(we_m), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_m), .tick_en(tick), .flush_done(fdone), .core_rst(crst_m),
    .core_clk_en(cen_m), .flush_req(fr_m));

  function automatic logic [31:0] ctrl_word(bit d, bit f, bit r);
    return (32'(d) << 12) | (32'(f) << 4) | 32'(r);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit m, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (m) we_m = 1'b1; else we_a = 1'b1;
    @(negedge clk);
    we_a = 1'b0; we_m = 1'b0;
  endtask

  task automatic rd(bit m, logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = m ? rd_m : rd_a;
  endtask

  task automatic measure(bit m, output int stop, output int hi);
    stop = 0; hi = 0;
    while (((m ? cen_m : cen_a) == 1'b0) && stop < 5000) begin
      stop++;
      if (m ? crst_m : crst_a) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int stop, hi;
    bit ef, ed;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, 8'h0, v); chk("R1 ctrl auto", v, 0);
    rd(1, 8'h0, v); chk("R1 ctrl man", v, 0);
    rd(0, 8'h4, v); chk("R1 ival", v, 15);
    chk("R1 outs", {29'd0, crst_a, cen_a, fr_a}, 32'b010);

    wr(0, 8'h0, 32'h0001_0001);
    measure(0, stop, hi);
    chk("R4 stop N=15", stop, 48);
    chk("R4 rst high N=15", hi, 16);
    rd(0, 8'h0, v); chk("R4 autoclear+done", v, 32'h1000);

    wr(0, 8'h0, 32'h0000_1000);
    rd(0, 8'h0, v); chk("R8 no mask keeps done", v, 32'h1000);
    wr(0, 8'h0, 32'h1000_1000);
    rd(0, 8'h0, v); chk("R8 clear done", v, 0);

    wr(0, 8'h4, 32'hFFFF_FFF3);
    rd(0, 8'h4, v); chk("R3 ival readback", v, 3);
    wr(0, 8'h0, 32'h0001_0001);
    measure(0, stop, hi);
    chk("R4 stop N=3", stop, 12);
    chk("R4 rst high N=3", hi, 4);
    wr(0, 8'h0, 32'h1000_1000);

    wr(0, 8'h0, 32'h0000_0001);
    chk("R2 unmasked reset write", {31'd0, cen_a}, 1);
    rd(0, 8'h0, v); chk("R2 unmasked reads 0", v, 0);
    wr(0, 8'h0, 32'h0001_0000);
    chk("R10 auto write 0 ignored", {31'd0, cen_a}, 1);

    wr(1, 8'h4, 32'h0);
    wr(1, 8'h0, 32'h0001_0001);
    measure(1, stop, hi);
    chk("R5 stop N=0", stop, 2);
    chk("R5 rst high", hi, 1);
    chk("R5 rst held", {31'd0, crst_m}, 1);
    rd(1, 8'h0, v); chk("R5 no done", v, 1);
    wr(1, 8'h0, 32'h0001_0000);
    measure(1, stop, hi);
    chk("R6 stop N=0", stop, 2);
    chk("R6 rst high before release", hi, 1);
    chk("R6 rst released", {31'd0, crst_m}, 0);
    rd(1, 8'h0, v); chk("R6 done", v, 32'h1000);
    wr(1, 8'h0, 32'h1000_1000);

    wr(1, 8'h4, 32'h5);
    wr(1, 8'h0, 32'h0001_0001);
    wr(1, 8'h0, 32'h0001_0000);
    measure(1, stop, hi);
    rd(1, 8'h0, v); chk("R10 busy write ignored", v, 1);
    chk("R10 rst still held", {31'd0, crst_m}, 1);
    wr(1, 8'h0, 32'h0001_0000);
    measure(1, stop, hi);
    chk("R6 stop N=5", stop, 12);

    tick = 1'b0;
    wr(0, 8'h0, 32'h0001_0001);
    repeat (40) @(negedge clk);
    chk("R11 stalled without ticks", {31'd0, cen_a}, 0);
    tick = 1'b1;
    measure(0, stop, hi);
    rd(0, 8'h0, v); chk("R11 completes after ticks", v, 32'h1000);
    wr(0, 8'h0, 32'h1000_1000);

    wr(0, 8'h0, 32'h0010_0010);
    chk("R9 flush set", {31'd0, fr_a}, 1);
    rd(0, 8'h0, v); chk("R9 flush reads", v, 32'h10);
    wr(0, 8'h0, 32'h0010_0000);
    chk("R9 write 0 no effect", {31'd0, fr_a}, 1);
    @(negedge clk); fdone = 1'b1;
    @(negedge clk); fdone = 1'b0;
    chk("R9 cleared by completion", {31'd0, fr_a}, 0);

    ed = 1'b0; ef = 1'b0;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = $urandom & 32'hFFFE_FFFF;
      if (i % 7 == 0) d = d | 32'h0010_0010;
      wr(0, 8'h0, d);
      if (d[20] && d[4]) ef = 1'b1;
      if (d[28] && d[12]) ed = 1'b0;
      rd(0, 8'h0, v);
      chk("R2 random masked write", v, ctrl_word(ed, ef, 1'b0));
      if (i % 5 == 4) begin
        @(negedge clk); fdone = 1'b1;
        @(negedge clk); fdone = 1'b0;
        ef = 1'b0;
      end
    end

    for (int i = 0; i < 10; i++) begin
      logic [31:0] d;
      d = $urandom;
      wr(1, 8'h4, d);
      rd(1, 8'h4, v);
      chk("R3 random interval", v, {28'd0, d[3:0]});
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule